// File: doc/BRIEF.md
# Time-Shared Multichannel FIR Filter

This block filters several independent sample streams with one multiplier and one accumulator. Each accepted sample starts one pass. The pass takes a full clock to store the sample, then one clock per tap, then a final clock that registers the rounded result. All channels use one common set of coefficients. Each channel keeps its own circular history of the last N samples, so the streams never mix. The block suits systems whose clock runs at N+2 times the aggregate sample rate or faster. Between passes it waits with its input ready high.

The sender holds a sample, with its channel number, on the input port until ready is high. Results come out one at a time in acceptance order. Each result carries the channel number of the sample that started its pass. Coefficients are written one per clock through a separate port, and only while no pass is running. A write attempted during a pass is dropped and reported on an error output.

Top module: `fir_mac_top`

## Requirements
- R1: After reset, `smp_ready` is 1, `res_valid` is 0 and `cf_err` is 0. All history entries and all coefficients are zero, so each channel's first results treat older samples as zero.
- R2: Coefficients and samples are signed W-bit two's complement values, with coefficients in Q1.(W-1) format. A result equals S = sum over k = 0..N-1 of c[k]·x[newest−k] of its channel, rounded as (S + 2^(W-2)) >> (W-1) with an arithmetic shift.
- R3: A sample is accepted on the edge where `smp_valid` and `smp_ready` are both 1. `res_valid` is 1 for exactly one cycle, which starts N+1 clock edges after the acceptance edge.
- R4: `smp_ready` is 0 from the acceptance edge until the edge that raises `res_valid`. A sample held on the input while ready is 0 is accepted exactly once, after ready returns.
- R5: Each channel's history is kept apart. Samples on one channel never change results on another channel.
- R6: `res_ch` equals the channel number of the sample that produced the result. Results leave in the order the samples were accepted.
- R7: A rounded result above 2^(W-1)−1 is clamped to 2^(W-1)−1, and one below −2^(W-1) is clamped to −2^(W-1).
- R8: A coefficient write made while `smp_ready` is 1 replaces c[`cf_idx`]. A write on the same edge as a sample acceptance is already used by that sample's pass.
- R9: A coefficient write made while `smp_ready` is 0 leaves all coefficients unchanged. It sets `cf_err` to 1 for the single cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample offered |
| smp_ch | input | $clog2(CH) | Channel of offered sample |
| smp_data | input | W | Signed sample value |
| smp_ready | output | 1 | Block can take a sample |
| cf_we | input | 1 | Coefficient write strobe |
| cf_idx | input | $clog2(N) | Tap number to write |
| cf_data | input | W | Signed Q1.(W-1) coefficient |
| cf_err | output | 1 | One-cycle flag for a write that was refused |
| res_valid | output | 1 | Result present |
| res_ch | output | $clog2(CH) | Channel of the result |
| res_data | output | W | Rounded, saturated result |

## Verification
Two functions can fall on the same clock edge: a coefficient write and the acceptance of a sample. The bench provokes this by raising both strobes in one cycle while the block is idle. The check passes only if the result already reflects the new coefficient. The opposite case is a write issued in the first busy cycle. It must raise the error flag one cycle later, and both the pending result and the next pass must still follow the old coefficient. A second sample held on the input through a whole pass checks that it is taken exactly once and that the results keep their order.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

    // Sequencer phases: waiting, multiply-accumulate, present result
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MAC  = 2'd1,
        PH_OUT  = 2'd2
    } phase_e;

    // Slot holding the sample 'step' places behind the write pointer in a ring of 'depth'
    function automatic int ring_back(input int base, input int step, input int depth);
        return (base + 2 * depth - step) % depth;
    endfunction

endpackage

// File: rtl/fir_mac_hist.sv
module fir_mac_hist #(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int CH = 4,
    localparam int PW = $clog2(N),
    localparam int CW = $clog2(CH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CW-1:0]       wr_ch,
    input  logic signed [W-1:0] wr_data,
    input  logic [CW-1:0]       rd_ch,
    input  logic [PW-1:0]       rd_back,
    output logic signed [W-1:0] rd_data
);
    logic [N-1:0][W-1:0] ring [CH];
    logic [PW-1:0]       wptr [CH];

    for (genvar g = 0; g < CH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                ring[g] <= '0;
                wptr[g] <= '0;
            end else if (wr_en && wr_ch == CW'(g)) begin
                ring[g][wptr[g]] <= wr_data;
                wptr[g]          <= (wptr[g] == PW'(N - 1)) ? '0 : wptr[g] + PW'(1);
            end
        end
    end

    logic [PW-1:0] slot;
    always_comb begin
        slot    = PW'(fir_mac_pkg::ring_back(int'(wptr[rd_ch]), int'(rd_back) + 1, N));
        rd_data = $signed(ring[rd_ch][slot]);
    end

endmodule

// File: rtl/fir_mac_coef.sv
module fir_mac_coef #(
    parameter int W = 16,
    parameter int N = 8,
    localparam int PW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                allow,
    input  logic                we,
    input  logic [PW-1:0]       wr_idx,
    input  logic signed [W-1:0] wr_data,
    input  logic [PW-1:0]       rd_idx,
    output logic signed [W-1:0] rd_coef,
    output logic                err
);
    logic [N-1:0][W-1:0] bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= '0;
            err  <= 1'b0;
        end else begin
            err <= we && !allow;
            if (we && allow && int'(wr_idx) < N)
                bank[wr_idx] <= wr_data;
        end
    end

    assign rd_coef = $signed(bank[rd_idx]);

    // R9: taps cannot change on the edge after a busy cycle
    a_r9_bank_frozen: assert property (@(posedge clk) disable iff (rst)
        !allow |=> $stable(bank));

endmodule

// File: rtl/fir_mac_seq.sv
module fir_mac_seq #(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int CH = 4,
    localparam int PW = $clog2(N),
    localparam int CW = $clog2(CH),
    localparam int AW = 2 * W + $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [CW-1:0]       smp_ch,
    output logic                smp_ready,
    output logic                take,
    output logic [CW-1:0]       cur_ch,
    output logic [PW-1:0]       tap,
    input  logic signed [W-1:0] hist_q,
    input  logic signed [W-1:0] coef_q,
    output logic                res_valid,
    output logic [CW-1:0]       res_ch,
    output logic signed [W-1:0] res_data
);
    import fir_mac_pkg::*;

    localparam logic signed [AW-1:0] HI  = (AW'(1) << (W - 1)) - AW'(1);
    localparam logic signed [AW-1:0] LO  = ~HI;
    localparam logic signed [AW-1:0] RND = AW'(1) << (W - 2);

    phase_e                phase;
    logic signed [AW-1:0]  acc;
    logic signed [2*W-1:0] prod;
    logic signed [AW-1:0]  rnd, shf;
    logic signed [W-1:0]   sat;

    assign smp_ready = (phase == PH_IDLE);
    assign take      = smp_valid && smp_ready;
    assign prod      = hist_q * coef_q;

    always_comb begin
        rnd = acc + RND;
        shf = rnd >>> (W - 1);
        if (shf > HI)      sat = HI[W-1:0];
        else if (shf < LO) sat = LO[W-1:0];
        else               sat = shf[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            acc       <= '0;
            tap       <= '0;
            cur_ch    <= '0;
            res_valid <= 1'b0;
            res_ch    <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            case (phase)
                PH_IDLE: if (take) begin
                    phase  <= PH_MAC;
                    acc    <= '0;
                    tap    <= '0;
                    cur_ch <= smp_ch;
                end
                PH_MAC: begin
                    acc <= acc + {{(AW - 2 * W){prod[2*W-1]}}, prod};
                    tap <= tap + PW'(1);
                    if (tap == PW'(N - 1))
                        phase <= PH_OUT;
                end
                default: begin
                    res_valid <= 1'b1;
                    res_ch    <= cur_ch;
                    res_data  <= sat;
                    phase     <= PH_IDLE;
                end
            endcase
        end
    end

    // R4: an accepted sample closes the input on the next cycle
    a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_ready) |=> !smp_ready);

    // R3: a result is a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R3: a result only follows a busy cycle
    a_r3_after_busy: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !$past(smp_ready));

    // R6: the channel being filtered holds through the taps
    a_r6_ch_steady: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MAC) |=> $stable(cur_ch));

endmodule

// File: rtl/fir_mac_top.sv
module fir_mac_top #(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int CH = 4,
    localparam int PW = $clog2(N),
    localparam int CW = $clog2(CH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [CW-1:0]       smp_ch,
    input  logic signed [W-1:0] smp_data,
    output logic                smp_ready,
    input  logic                cf_we,
    input  logic [PW-1:0]       cf_idx,
    input  logic signed [W-1:0] cf_data,
    output logic                cf_err,
    output logic                res_valid,
    output logic [CW-1:0]       res_ch,
    output logic signed [W-1:0] res_data
);
    logic                take;
    logic [CW-1:0]       cur_ch;
    logic [PW-1:0]       tap;
    logic signed [W-1:0] hist_q, coef_q;

    fir_mac_seq #(.W(W), .N(N), .CH(CH)) u_seq (
        .clk(clk), .rst(rst),
        .smp_valid(smp_valid), .smp_ch(smp_ch), .smp_ready(smp_ready),
        .take(take), .cur_ch(cur_ch), .tap(tap),
        .hist_q(hist_q), .coef_q(coef_q),
        .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data)
    );

    fir_mac_hist #(.W(W), .N(N), .CH(CH)) u_hist (
        .clk(clk), .rst(rst),
        .wr_en(take), .wr_ch(smp_ch), .wr_data(smp_data),
        .rd_ch(cur_ch), .rd_back(tap), .rd_data(hist_q)
    );

    fir_mac_coef #(.W(W), .N(N)) u_coef (
        .clk(clk), .rst(rst),
        .allow(smp_ready), .we(cf_we), .wr_idx(cf_idx), .wr_data(cf_data),
        .rd_idx(tap), .rd_coef(coef_q), .err(cf_err)
    );

endmodule

// File: tb/sim_fir_mac_top.sv
module sim_fir_mac_top;
    localparam int W = 16, N = 8, CH = 4;

    logic clk = 0, rst = 1;
    logic smp_valid = 0, cf_we = 0;
    logic [1:0] smp_ch = '0;
    logic [2:0] cf_idx = '0;
    logic signed [15:0] smp_data = '0, cf_data = '0;
    logic smp_ready, cf_err, res_valid;
    logic [1:0] res_ch;
    logic signed [15:0] res_data;

    int checks = 0, errors = 0;
    int cm [N];
    int hm [CH][N];

    always #4 clk = ~clk;

    fir_mac_top #(.W(W), .N(N), .CH(CH)) u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ch(smp_ch),
        .smp_data(smp_data), .smp_ready(smp_ready), .cf_we(cf_we),
        .cf_idx(cf_idx), .cf_data(cf_data), .cf_err(cf_err),
        .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model_y(input int c);
        longint a = 0;
        for (int k = 0; k < N; k++) a += longint'(cm[k]) * longint'(hm[c][k]);
        a = (a + 16384) >>> 15;
        if (a > 32767) a = 32767;
        if (a < -32768) a = -32768;
        return a;
    endfunction

    task automatic push_model(input int c, input int x);
        for (int k = N - 1; k > 0; k--) hm[c][k] = hm[c][k-1];
        hm[c][0] = x;
    endtask

    task automatic load_coef(input int i, input int v);
        @(negedge clk);
        cf_we = 1; cf_idx = 3'(i); cf_data = 16'(v);
        @(negedge clk);
        cf_we = 0;
        cm[i] = v;
    endtask

    // Called at the first negedge after the acceptance edge
    task automatic finish(input int c, input string req);
        int cnt = 0;
        longint e = model_y(c);
        chk(smp_ready == 0, "R4 busy", smp_ready, 0);
        while (!res_valid && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == N + 1, "R3 latency", cnt, N + 1);
        chk(res_data == e, req, res_data, e);
        chk(res_ch == 2'(c), "R6 channel", res_ch, c);
        chk(smp_ready == 1, "R4 ready back", smp_ready, 1);
    endtask

    task automatic run_sample(input int c, input int x, input string req);
        @(negedge clk);
        smp_valid = 1; smp_ch = 2'(c); smp_data = 16'(x);
        @(negedge clk);
        smp_valid = 0;
        push_model(c, x);
        finish(c, req);
    endtask

    task automatic t_reset;
        chk(smp_ready == 1, "R1 ready", smp_ready, 1);
        chk(res_valid == 0, "R1 valid", res_valid, 0);
        chk(cf_err == 0, "R1 err", cf_err, 0);
        run_sample(1, 12345, "R1 zero coefs");
        for (int i = 0; i < N; i++) load_coef(i, 4096 * (i + 1) - 9000);
        run_sample(1, -3000, "R1 zero-padded history");
    endtask

    task automatic t_channels;
        for (int i = 0; i < 12; i++)
            run_sample(i % 2 == 0 ? 0 : 2, (i * 7919) % 30000 - 15000, "R2 value");
        run_sample(3, 2000, "R5 fresh channel");
        run_sample(0, -1, "R5 channel 0 kept");
    endtask

    task automatic t_backpressure;
        @(negedge clk);
        smp_valid = 1; smp_ch = 2'd1; smp_data = 16'sd5000;
        @(negedge clk);
        push_model(1, 5000);
        smp_ch = 2'd3; smp_data = -16'sd7000;
        finish(1, "R4 first of pair");
        @(negedge clk);
        smp_valid = 0;
        push_model(3, -7000);
        finish(3, "R4 held sample taken once");
    endtask

    task automatic t_saturate;
        for (int i = 0; i < N; i++) load_coef(i, 32767);
        for (int i = 0; i < N; i++) run_sample(2, 32767, "R7 positive");
        chk(res_data == 32767, "R7 high clamp", res_data, 32767);
        for (int i = 0; i < N; i++) run_sample(2, -32768, "R7 negative");
        chk(res_data == -32768, "R7 low clamp", res_data, -32768);
    endtask

    task automatic t_same_cycle;
        for (int i = 0; i < N; i++) load_coef(i, 1000 + 300 * i);
        @(negedge clk);
        smp_valid = 1; smp_ch = 2'd0; smp_data = 16'sd9000;
        cf_we = 1; cf_idx = 3'd0; cf_data = -16'sd20000;
        @(negedge clk);
        smp_valid = 0; cf_we = 0;
        cm[0] = -20000;
        push_model(0, 9000);
        chk(cf_err == 0, "R8 no error when idle", cf_err, 0);
        finish(0, "R8 same-edge coefficient");
    endtask

    task automatic t_busy_load;
        @(negedge clk);
        smp_valid = 1; smp_ch = 2'd2; smp_data = 16'sd1234;
        @(negedge clk);
        smp_valid = 0;
        push_model(2, 1234);
        cf_we = 1; cf_idx = 3'd0; cf_data = 16'sd31000;
        @(negedge clk);
        cf_we = 0;
        chk(cf_err == 1, "R9 error flag", cf_err, 1);
        @(negedge clk);
        chk(cf_err == 0, "R9 flag one cycle", cf_err, 0);
        begin
            int cnt = 2;
            longint e = model_y(2);
            while (!res_valid && cnt < 100) begin
                @(negedge clk);
                cnt++;
            end
            chk(cnt == N + 1, "R3 latency", cnt, N + 1);
            chk(res_data == e, "R9 pass unchanged", res_data, e);
        end
        run_sample(2, -4321, "R9 later pass unchanged");
    endtask

    initial begin
        for (int i = 0; i < N; i++) cm[i] = 0;
        for (int c = 0; c < CH; c++)
            for (int k = 0; k < N; k++) hm[c][k] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_channels;
        t_backpressure;
        t_saturate;
        t_same_cycle;
        t_busy_load;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule